// File: doc/BRIEF.md
# Half-Bridge Dead-Time Generator with Mirrored Storage-Delay Compensation

This block alternates the low-side and high-side gate drives of a half bridge and puts a dead interval between them. After the low side switches off, the block waits until a comparator on the bridge midpoint reports that the node has swung high. It then waits a fixed delay and turns the high side on. It counts the whole interval from low-side off to high-side on. It then applies that same count as the dead interval between high-side off and the following low-side on. This way, a switch with a slow turn-off (storage delay) gets the same safety margin on both transitions without any per-part tuning.

Each ON phase lasts one half-period minus the most recently measured gap. The half-period is given in clock cycles. Each ON phase is never shorter than a minimum ON length. If that minimum is in force without a break for a long window, the block latches a fault and holds both gates low until reset. If the comparator never rises, a timeout of the largest encodable half-period turns the high side on anyway, and that interval is recorded as the gap.

Top module: `hb_deadtime_mirror`

## Requirements
- R1: When the comparator is first sampled high in gap cycle k after the low side falls, the high side rises exactly k + FIXED_DT cycles after the low-side fall, and k + FIXED_DT is recorded as the gap.
- R2: When the comparator is already high in the first gap cycle (no storage delay), the low-off to high-on dead time is exactly FIXED_DT cycles.
- R3: The interval from high-side fall to the next low-side rise equals the most recently recorded gap.
- R4: Each ON phase lasts half_period minus the most recently recorded gap, in clock cycles.
- R5: When half_period minus the gap is below MIN_ON, the ON phase lasts MIN_ON cycles. When the difference equals MIN_ON, no clamping takes place.
- R6: If the comparator stays low for 2^HP_W-1 gap cycles, the high side is forced on at gap cycle 2^HP_W-1, and that value is recorded as the gap.
- R7: When the minimum-ON clamp condition holds for WD_CYC consecutive clock cycles, fault_latched rises and both gates go low. This state persists regardless of inputs until reset.
- R8: lo_gate and hi_gate are never high together. During reset both gates and fault_latched are low. After reset is released, lo_gate first rises after FIXED_DT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | HP_W | Half switching period in clock cycles |
| mid_above | input | 1 | Midpoint comparator, high when the node is above threshold |
| lo_gate | output | 1 | Low-side gate drive |
| hi_gate | output | 1 | High-side gate drive |
| fault_latched | output | 1 | Latched shutdown after a sustained minimum-ON clamp |

## Verification
The comparator is modelled as rising a chosen number of cycles after the low side falls. Several delays are used:
- A zero delay shows that the fixed dead time alone is applied.
- Nonzero delays show that the wait is added to the fixed part and then mirrored onto the opposite edge.
- A delay past the timeout separates the forced turn-on from a normal one.

Half-periods are chosen around the clamp point (one below, one exactly at it) to separate the subtraction from the MIN_ON floor. A held clamp condition then confirms the exact cycle of the shutdown and that it persists after the inputs recover.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;
    typedef enum logic [2:0] {
        PH_LO_ON   = 3'd0,
        PH_WAIT_HI = 3'd1,
        PH_HI_ON   = 3'd2,
        PH_WAIT_LO = 3'd3,
        PH_TRIP    = 3'd4
    } phase_e;
endpackage

// File: rtl/hbdt_ontime.sv
module hbdt_ontime #(
    parameter int HP_W   = 10,
    parameter int GAP_W  = 11,
    parameter int MIN_ON = 50
) (
    input  logic [HP_W-1:0]  half_period,
    input  logic [GAP_W-1:0] gap,
    output logic [GAP_W-1:0] on_len,
    output logic             clamp
);
    localparam int EW = GAP_W + 1;

    logic [EW-1:0] hp_x;
    logic [EW-1:0] need_x;
    logic [EW-1:0] diff_x;

    always_comb begin
        hp_x   = EW'(half_period);
        need_x = EW'(gap) + EW'(MIN_ON);
        diff_x = hp_x - EW'(gap);
        clamp  = (hp_x < need_x);
        on_len = clamp ? GAP_W'(MIN_ON) : diff_x[GAP_W-1:0];
    end
endmodule

// File: rtl/hbdt_wdog.sv
module hbdt_wdog #(
    parameter int WD_CYC = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clamp,
    output logic trip
);
    localparam int WD_W = $clog2(WD_CYC + 1);

    logic [WD_W-1:0] wd_d, wd_q;

    always_comb begin
        wd_d = clamp ? wd_q + WD_W'(1) : '0;
        trip = clamp && (wd_q == WD_W'(WD_CYC - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end
endmodule

// File: rtl/hb_deadtime_mirror.sv
module hb_deadtime_mirror #(
    parameter int HP_W     = 10,
    parameter int FIXED_DT = 71,
    parameter int MIN_ON   = 50,
    parameter int WD_CYC   = 10_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HP_W-1:0] half_period,
    input  logic            mid_above,
    output logic            lo_gate,
    output logic            hi_gate,
    output logic            fault_latched
);
    import hbdt_pkg::*;

    localparam int MAXW  = (2 ** HP_W) - 1;
    localparam int GAP_W = $clog2(MAXW + FIXED_DT + 1);
    localparam int DLY_W = $clog2(FIXED_DT + 1);

    typedef struct packed {
        phase_e           ph;
        logic [GAP_W-1:0] cnt;
        logic [GAP_W-1:0] gap;
        logic             armed;
        logic [DLY_W-1:0] dly;
    } core_t;

    core_t            cs_q, cs_d;
    logic [GAP_W-1:0] on_len;
    logic             clamp;
    logic             trip;

    hbdt_ontime #(.HP_W(HP_W), .GAP_W(GAP_W), .MIN_ON(MIN_ON)) ontime_i (
        .half_period (half_period),
        .gap         (cs_q.gap),
        .on_len      (on_len),
        .clamp       (clamp)
    );

    hbdt_wdog #(.WD_CYC(WD_CYC)) wdog_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clamp (clamp),
        .trip  (trip)
    );

    always_comb begin
        cs_d = cs_q;
        unique case (cs_q.ph)
            PH_LO_ON: begin
                if (cs_q.cnt >= on_len - GAP_W'(1)) begin
                    cs_d.ph    = PH_WAIT_HI;
                    cs_d.cnt   = '0;
                    cs_d.armed = 1'b0;
                    cs_d.dly   = '0;
                end else begin
                    cs_d.cnt = cs_q.cnt + GAP_W'(1);
                end
            end
            PH_WAIT_HI: begin
                cs_d.cnt = cs_q.cnt + GAP_W'(1);
                if (cs_q.armed) begin
                    if (cs_q.dly == DLY_W'(FIXED_DT - 1)) begin
                        cs_d.ph  = PH_HI_ON;
                        cs_d.gap = cs_q.cnt + GAP_W'(1);
                        cs_d.cnt = '0;
                    end else begin
                        cs_d.dly = cs_q.dly + DLY_W'(1);
                    end
                end else if (mid_above) begin
                    cs_d.armed = 1'b1;
                    cs_d.dly   = DLY_W'(1);
                end else if (cs_q.cnt == GAP_W'(MAXW - 1)) begin
                    cs_d.ph  = PH_HI_ON;
                    cs_d.gap = cs_q.cnt + GAP_W'(1);
                    cs_d.cnt = '0;
                end
            end
            PH_HI_ON: begin
                if (cs_q.cnt >= on_len - GAP_W'(1)) begin
                    cs_d.ph  = PH_WAIT_LO;
                    cs_d.cnt = '0;
                end else begin
                    cs_d.cnt = cs_q.cnt + GAP_W'(1);
                end
            end
            PH_WAIT_LO: begin
                if (cs_q.cnt >= cs_q.gap - GAP_W'(1)) begin
                    cs_d.ph  = PH_LO_ON;
                    cs_d.cnt = '0;
                end else begin
                    cs_d.cnt = cs_q.cnt + GAP_W'(1);
                end
            end
            default: cs_d.ph = PH_TRIP;
        endcase
        if (trip) cs_d.ph = PH_TRIP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.ph    <= PH_WAIT_LO;
            cs_q.cnt   <= '0;
            cs_q.gap   <= GAP_W'(FIXED_DT);
            cs_q.armed <= 1'b0;
            cs_q.dly   <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign lo_gate       = (cs_q.ph == PH_LO_ON);
    assign hi_gate       = (cs_q.ph == PH_HI_ON);
    assign fault_latched = (cs_q.ph == PH_TRIP);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_gate && hi_gate));

    a_r1_fixed_delay_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.ph == PH_WAIT_HI && cs_q.armed && cs_q.dly != DLY_W'(FIXED_DT - 1))
        |=> !hi_gate);

    a_r3_mirror_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.ph == PH_WAIT_LO) |-> (cs_q.cnt < cs_q.gap));

    a_r5_min_on_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_gate && cs_q.cnt < GAP_W'(MIN_ON - 1)) |=> (lo_gate || fault_latched));

    a_r6_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.ph == PH_WAIT_HI && !cs_q.armed) |-> (cs_q.cnt < GAP_W'(MAXW)));

    a_r7_trip_from_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_latched) |-> $past(clamp));

    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |=> (fault_latched && !lo_gate && !hi_gate));
endmodule

// File: tb/hb_deadtime_mirror_tb_top.sv
module hb_deadtime_mirror_tb_top;
    localparam int HP_W = 8;
    localparam int FDT  = 4;
    localparam int MON  = 5;
    localparam int WD   = 3000;
    localparam int NV   = 8;

    // half_period, comparator delay k, expected gap, expected ON length
    localparam int VEC [NV][4] = '{
        '{40,   0,   4, 36},
        '{40,   6,  10, 30},
        '{25,  13,  17,  8},
        '{18,  10,  14,  5},
        '{19,  10,  14,  5},
        '{100, 300, 255, 5},
        '{60,   2,   6, 54},
        '{40,   0,   4, 36}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [HP_W-1:0] half_period = 8'd40;
    logic            mid_above = 1'b0;
    logic            lo_gate, hi_gate, fault_latched;

    int checks = 0;
    int errors = 0;
    int k_sim = 0;
    int overlap = 0;
    int cyc = 0;
    int mcnt = 0;
    logic mwatch = 1'b0;

    always #10 clk = ~clk;

    hb_deadtime_mirror #(.HP_W(HP_W), .FIXED_DT(FDT), .MIN_ON(MON), .WD_CYC(WD)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .half_period   (half_period),
        .mid_above     (mid_above),
        .lo_gate       (lo_gate),
        .hi_gate       (hi_gate),
        .fault_latched (fault_latched)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // midpoint model: rises k_sim cycles into the low-off gap
    always @(negedge clk) begin
        if (lo_gate && hi_gate) overlap++;
        if (lo_gate) begin
            mid_above <= 1'b0;
            mcnt      <= 0;
            mwatch    <= 1'b1;
        end else if (mwatch) begin
            if (hi_gate) mwatch <= 1'b0;
            else if (mcnt == k_sim) begin
                mid_above <= 1'b1;
                mwatch    <= 1'b0;
            end else mcnt <= mcnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic measure(output int l_len, output int g1, output int h_len, output int g2);
        l_len = 0; g1 = 0; h_len = 0; g2 = 0;
        while (lo_gate) begin l_len++; @(negedge clk); end
        while (!lo_gate && !hi_gate && !fault_latched) begin g1++; @(negedge clk); end
        while (hi_gate) begin h_len++; @(negedge clk); end
        while (!lo_gate && !hi_gate && !fault_latched) begin g2++; @(negedge clk); end
    endtask

    initial begin
        int l_len, g1, h_len, g2;
        repeat (3) @(negedge clk);
        chk("R8 reset lo", int'(lo_gate), 0);
        chk("R8 reset hi", int'(hi_gate), 0);
        chk("R8 reset fault", int'(fault_latched), 0);
        rst_n = 1'b1;
        repeat (FDT - 1) @(negedge clk);
        chk("R8 lo not yet", int'(lo_gate), 0);
        @(negedge clk);
        chk("R8 lo after FIXED_DT", int'(lo_gate), 1);

        for (int v = 0; v < NV; v++) begin
            half_period = HP_W'(VEC[v][0]);
            k_sim = VEC[v][1];
            measure(l_len, g1, h_len, g2);
            measure(l_len, g1, h_len, g2);
            if (v == 0) chk("R2 no storage dead time", g1, FDT);
            if (v == 5) chk("R6 timeout gap", g1, VEC[v][2]);
            else        chk("R1 low-off to high-on gap", g1, VEC[v][2]);
            chk("R3 mirrored gap", g2, VEC[v][2]);
            if (v == 3 || v == 4 || v == 5) begin
                chk("R5 high ON floor", h_len, VEC[v][3]);
                chk("R5 low ON floor", l_len, VEC[v][3]);
            end else begin
                chk("R4 high ON", h_len, VEC[v][3]);
                chk("R4 low ON", l_len, VEC[v][3]);
            end
        end

        // sustained clamp: 6 - 4 < 5
        half_period = HP_W'(6);
        repeat (WD - 1) @(negedge clk);
        chk("R7 no fault before window", int'(fault_latched), 0);
        @(negedge clk);
        chk("R7 fault at window end", int'(fault_latched), 1);
        chk("R7 lo low in fault", int'(lo_gate), 0);
        chk("R7 hi low in fault", int'(hi_gate), 0);
        half_period = HP_W'(40);
        repeat (40) @(negedge clk);
        chk("R7 fault sticky", int'(fault_latched), 1);
        chk("R7 gates stay low", int'(lo_gate | hi_gate), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset clears fault", int'(fault_latched), 0);
        chk("R8 reset gates low", int'(lo_gate | hi_gate), 0);
        chk("R8 never overlapped", overlap, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule